// File: doc/BRIEF.md
# Count/Compare Match Timer

This block is a processor-side timer. A free-running Count register goes up by one on each tick-enable pulse. A Compare register holds the value software is waiting for. When an increment makes Count equal to Compare, the timer raises its hardware interrupt line (line 7 of the core's interrupt inputs). The line stays high until software writes Compare again. That write is the only way to acknowledge the interrupt.

A freeze input stops the counter while it is held. Both registers can be loaded through single-cycle write strobes and are always visible on read-back ports. A 3-bit revision input selects whether a cause-register pending bit follows the interrupt line. The bit is tracked only when the revision equals 1. For any other revision it keeps its last value. Conversion from a host clock into tick pulses happens outside this block.

Top module: `tick_match_timer`

## Requirements
- R1: After reset, Count reads 1, Compare reads 0, and both the interrupt line and the pending bit are low.
- R2: On each cycle with the tick enable high, freeze low and no Count write, Count rises by exactly one. Without a tick, Count holds its value.
- R3: Count wraps from all ones to zero.
- R4: While freeze is high, Count does not change on ticks, and a tick cannot produce a match.
- R5: A Count write loads the written value on the next edge and takes priority over a tick. Counting then continues upward from the loaded value.
- R6: A Compare write loads the written value on the next edge, and it is visible on the Compare read-back port.
- R7: A match happens when a tick increment gives a value equal to the current Compare. The interrupt line goes high on the same edge that stores that value. Loading a Count equal to Compare through a write is not a match.
- R8: Once high, the interrupt line stays high until a Compare write. Further matches change nothing.
- R9: A Compare write drives the interrupt line low on the next edge. This holds even if a match occurs in the same cycle, because the write wins.
- R10: While the revision input equals 1, a match sets the pending bit and a Compare write clears it. The write wins when both occur in the same cycle.
- R11: While the revision input is any value other than 1, the pending bit holds its value through matches and Compare writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count advance pulse |
| count_freeze | input | 1 | Holds Count while high |
| arch_rev | input | 3 | Revision field; value 1 enables the pending bit |
| count_wr | input | 1 | Count write strobe |
| count_wdata | input | WIDTH | Count write value |
| cmp_wr | input | 1 | Compare write strobe; acknowledges the interrupt |
| cmp_wdata | input | WIDTH | Compare write value |
| count_q | output | WIDTH | Count read-back |
| cmp_q | output | WIDTH | Compare read-back |
| timer_irq | output | 1 | Interrupt line 7 |
| cause_pending | output | 1 | Cause-register timer pending bit |

## Verification
The bench uses an 8-bit configuration and sweeps every Compare value. For each one it loads Count three below Compare and ticks toward it, so an early match, a late match or an off-by-one is caught at every position, including across the wrap. Separate sequences place a tick, freeze or Count write next to a match, to separate a real increment match from a frozen tick or a direct load. Other sequences put a Compare write in the same cycle as a match, to show that the acknowledge wins. Further sequences switch the revision input between 1 and other values, which checks that the pending bit is set, cleared or left alone only as the revision allows.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [2:0] REV_MIRROR = 3'd1;

  typedef enum logic [1:0] {
    FLAG_HOLD  = 2'd0,
    FLAG_SET   = 2'd1,
    FLAG_CLEAR = 2'd2
  } flag_op_e;

  function automatic flag_op_e flag_decide(input logic ack, input logic hit);
    if (ack)      return FLAG_CLEAR;
    else if (hit) return FLAG_SET;
    else          return FLAG_HOLD;
  endfunction
endpackage

// File: rtl/tmr_count_unit.sv
module tmr_count_unit #(
  parameter int          WIDTH     = 32,
  parameter logic [WIDTH-1:0] RESET_VAL = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             freeze,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] count_q,
  output logic [WIDTH-1:0] count_inc,
  output logic             adv
);
  logic [WIDTH-1:0] count_d;
  logic             count_en;

  always_comb begin
    count_inc = count_q + WIDTH'(1);
    adv       = tick_en && !freeze && !wr_en;
    count_en  = wr_en || adv;
    count_d   = wr_en ? wr_data : count_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= RESET_VAL;
    else if (count_en) count_q <= count_d;
  end

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !freeze && !wr_en) |=> count_q == WIDTH'($past(count_q) + WIDTH'(1)));
  assert_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !wr_en) |=> $stable(count_q));
  assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> count_q == $past(wr_data));
endmodule

// File: rtl/tmr_compare_unit.sv
module tmr_compare_unit #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             adv,
  input  logic [WIDTH-1:0] count_inc,
  output logic [WIDTH-1:0] cmp_q,
  output logic             hit
);
  logic [WIDTH-1:0] cmp_d;

  always_comb begin
    cmp_d = wr_data;
    hit   = adv && (count_inc == cmp_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cmp_q <= '0;
    else if (wr_en) cmp_q <= cmp_d;
  end

  assert_cmp_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> cmp_q == $past(wr_data));
  assert_cmp_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cmp_q));
endmodule

// File: rtl/tmr_irq_unit.sv
module tmr_irq_unit
  import tmr_pkg::*;
#(
  parameter bit HAS_MIRROR = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hit,
  input  logic       ack,
  input  logic [2:0] arch_rev,
  output logic       irq_q,
  output logic       pend_q
);
  flag_op_e op;
  logic     irq_d;

  always_comb begin
    op    = flag_decide(ack, hit);
    irq_d = irq_q;
    case (op)
      FLAG_SET:   irq_d = 1'b1;
      FLAG_CLEAR: irq_d = 1'b0;
      default:    irq_d = irq_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  generate
    if (HAS_MIRROR) begin : g_mirror
      logic pend_d;
      logic pend_en;
      always_comb begin
        pend_en = (arch_rev == REV_MIRROR) && (op != FLAG_HOLD);
        pend_d  = (op == FLAG_SET);
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       pend_q <= 1'b0;
        else if (pend_en) pend_q <= pend_d;
      end

      assert_pend_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (arch_rev == REV_MIRROR && hit && !ack) |=> pend_q);
      assert_pend_clr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (arch_rev == REV_MIRROR && ack) |=> !pend_q);
      assert_pend_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (arch_rev != REV_MIRROR) |=> $stable(pend_q));
    end else begin : g_no_mirror
      assign pend_q = 1'b0;
    end
  endgenerate

  assert_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !irq_q);
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !ack) |=> irq_q);
  assert_raise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !ack) |=> irq_q);
  assert_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_q && !hit) |=> !irq_q);
endmodule

// File: rtl/tick_match_timer.sv
module tick_match_timer #(
  parameter int WIDTH      = 32,
  parameter bit HAS_MIRROR = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             count_freeze,
  input  logic [2:0]       arch_rev,
  input  logic             count_wr,
  input  logic [WIDTH-1:0] count_wdata,
  input  logic             cmp_wr,
  input  logic [WIDTH-1:0] cmp_wdata,
  output logic [WIDTH-1:0] count_q,
  output logic [WIDTH-1:0] cmp_q,
  output logic             timer_irq,
  output logic             cause_pending
);
  localparam logic [WIDTH-1:0] COUNT_INIT = WIDTH'(1);

  logic [WIDTH-1:0] count_inc;
  logic             adv;
  logic             hit;

  tmr_count_unit #(.WIDTH(WIDTH), .RESET_VAL(COUNT_INIT)) u_count (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .freeze(count_freeze),
    .wr_en(count_wr), .wr_data(count_wdata),
    .count_q(count_q), .count_inc(count_inc), .adv(adv)
  );

  tmr_compare_unit #(.WIDTH(WIDTH)) u_compare (
    .clk(clk), .rst_n(rst_n), .wr_en(cmp_wr), .wr_data(cmp_wdata),
    .adv(adv), .count_inc(count_inc), .cmp_q(cmp_q), .hit(hit)
  );

  tmr_irq_unit #(.HAS_MIRROR(HAS_MIRROR)) u_irq (
    .clk(clk), .rst_n(rst_n), .hit(hit), .ack(cmp_wr), .arch_rev(arch_rev),
    .irq_q(timer_irq), .pend_q(cause_pending)
  );

  assert_no_load_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (count_wr && !timer_irq) |=> !timer_irq);
endmodule

// File: tb/tick_match_timer_bench.sv
`timescale 1ns/100ps
module tick_match_timer_bench;
  localparam int W = 8;
  localparam logic [W-1:0] ALL1 = '1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick_en = 1'b0;
  logic         count_freeze = 1'b0;
  logic [2:0]   arch_rev = 3'd1;
  logic         count_wr = 1'b0;
  logic [W-1:0] count_wdata = '0;
  logic         cmp_wr = 1'b0;
  logic [W-1:0] cmp_wdata = '0;
  logic [W-1:0] count_q;
  logic [W-1:0] cmp_q;
  logic         timer_irq;
  logic         cause_pending;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tick_match_timer #(.WIDTH(W), .HAS_MIRROR(1'b1)) u_tick_match_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .count_freeze(count_freeze),
    .arch_rev(arch_rev), .count_wr(count_wr), .count_wdata(count_wdata),
    .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .count_q(count_q), .cmp_q(cmp_q),
    .timer_irq(timer_irq), .cause_pending(cause_pending)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One clock: inputs set by caller at negedge, results sampled next negedge.
  task automatic cyc(input bit t, input bit cw, input logic [W-1:0] cv,
                     input bit mw, input logic [W-1:0] mv);
    tick_en = t; count_wr = cw; count_wdata = cv; cmp_wr = mw; cmp_wdata = mv;
    @(negedge clk);
    tick_en = 0; count_wr = 0; cmp_wr = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(count_q == 1, "R1 count", count_q, 1);
    chk(cmp_q == 0, "R1 compare", cmp_q, 0);
    chk(!timer_irq, "R1 irq", timer_irq, 0);
    chk(!cause_pending, "R1 pending", cause_pending, 0);
    // R2 hold without tick, then step
    cyc(0, 0, 0, 0, 0);
    chk(count_q == 1, "R2 hold", count_q, 1);
    cyc(1, 0, 0, 0, 0);
    chk(count_q == 2, "R2 step", count_q, 2);

    // Sweep every compare value, approaching from three below
    for (int k = 0; k < 256; k++) begin
      c = W'(k);
      cyc(0, 1, W'(c - 3), 1, c);
      chk(cmp_q == c, "R6 compare load", cmp_q, c);
      chk(count_q == W'(c - 3), "R5 count load", count_q, W'(c - 3));
      chk(!timer_irq, "R9 ack", timer_irq, 0);
      chk(!cause_pending, "R10 clear", cause_pending, 0);
      for (int s = 1; s <= 2; s++) begin
        cyc(1, 0, 0, 0, 0);
        chk(count_q == W'(c - 3 + s), "R2 sweep step", count_q, W'(c - 3 + s));
        chk(!timer_irq, "R7 early", timer_irq, 0);
      end
      cyc(1, 0, 0, 0, 0);
      chk(count_q == c, "R2 reach", count_q, c);
      chk(timer_irq, "R7 match", timer_irq, 1);
      chk(cause_pending, "R10 set", cause_pending, 1);
    end

    // R3 wrap
    cyc(0, 1, ALL1, 1, 8'd50);
    cyc(1, 0, 0, 0, 0);
    chk(count_q == 0, "R3 wrap", count_q, 0);
    cyc(1, 0, 0, 0, 0);
    chk(count_q == 1, "R5 continue after load", count_q, 1);

    // R5 write beats tick
    cyc(1, 1, 8'd20, 0, 0);
    chk(count_q == 20, "R5 write over tick", count_q, 20);

    // R4 freeze, including a would-be match
    cyc(0, 1, 8'd49, 0, 0);
    count_freeze = 1'b1;
    for (int s = 0; s < 4; s++) begin
      cyc(1, 0, 0, 0, 0);
      chk(count_q == 49, "R4 frozen", count_q, 49);
      chk(!timer_irq, "R4 no match", timer_irq, 0);
    end
    count_freeze = 1'b0;
    cyc(1, 0, 0, 0, 0);
    chk(timer_irq && count_q == 50, "R7 after unfreeze", timer_irq, 1);

    // R8 sticky: ticks and a second match keep line high
    for (int s = 0; s < 300; s++) begin
      cyc(1, 0, 0, 0, 0);
      chk(timer_irq, "R8 sticky", timer_irq, 1);
    end
    cyc(0, 0, 0, 1, 8'd50);
    chk(!timer_irq, "R9 ack after sticky", timer_irq, 0);

    // R7 a Count load equal to Compare is not a match
    cyc(0, 1, 8'd50, 0, 0);
    chk(!timer_irq, "R7 load no match", timer_irq, 0);

    // R9/R10 compare write in the same cycle as a match wins
    cyc(0, 1, 8'd49, 0, 0);
    cyc(1, 0, 0, 1, 8'd50);
    chk(count_q == 50, "R9 count advanced", count_q, 50);
    chk(!timer_irq, "R9 write wins", timer_irq, 0);
    chk(!cause_pending, "R10 write wins", cause_pending, 0);

    // R11 revision other than 1: pending frozen
    cyc(0, 1, 8'd49, 0, 0);
    cyc(1, 0, 0, 0, 0);
    chk(cause_pending, "R10 set again", cause_pending, 1);
    arch_rev = 3'd0;
    cyc(0, 0, 0, 1, 8'd50);
    chk(!timer_irq, "R9 ack rev0", timer_irq, 0);
    chk(cause_pending, "R11 hold on ack", cause_pending, 1);
    arch_rev = 3'd1;
    cyc(0, 0, 0, 1, 8'd50);
    chk(!cause_pending, "R10 clear rev1", cause_pending, 0);
    arch_rev = 3'd2;
    cyc(0, 1, 8'd49, 0, 0);
    cyc(1, 0, 0, 0, 0);
    chk(timer_irq, "R7 match rev2", timer_irq, 1);
    chk(!cause_pending, "R11 hold on match", cause_pending, 0);
    arch_rev = 3'd7;
    cyc(0, 0, 0, 1, 8'd9);
    chk(!timer_irq && !cause_pending, "R11 rev7 ack", cause_pending, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule